// File: doc/BRIEF.md
# Routing Code Selector with Analyzer Handshake

This block produces the 4-bit channel code that tells a downstream pulse-height analyzer which input an event came from. It also steers the analog input multiplexer. Two sources can supply the code, and a mode input chooses between them. In multiplex mode the block uses the channel identity that the capture logic has latched for the current event. In single-channel mode it uses a manual channel taken from a 16-position selector. The block registers the chosen code once per clock. The registered code drives the analog multiplexer select lines in inverted form, so those lines change only at a clock edge.

The code reaches the analyzer on low-true routing lines. It appears there only while a transfer is enabled, and the lines rest all-high otherwise. A transfer is enabled by the analyzer's strobe, whose active level is set by a configuration input. In a system with several analyzers, this unit's own select line must also be high. The manual selector is sampled only while no event is being routed. Positions outside 1..16 are disregarded.

Top module: `route_code_sel`

## Requirements
- R1: With `mux_mode` high (multiplex), `amux_sel_n` equals the bitwise inverse of the `ev_code` sampled at the previous rising clock edge. Bit i of `amux_sel_n` is the inverse of code bit i.
- R2: With `mux_mode` low (single channel), `amux_sel_n` equals the inverse of the held manual channel one clock after the mode is sampled low.
- R3: Selector position p on `sel_pos`, for p from 1 to 16, sets manual channel p-1.
- R4: Selector positions 0 and 17..31 leave the held manual channel unchanged.
- R5: `sel_pos` is sampled only at edges where `ev_busy` is low. While `ev_busy` is high, the held manual channel is retained.
- R6: In single-channel mode, a new valid position shows on `amux_sel_n` two rising edges after it is applied. After one edge the old value is still shown.
- R7: With `stb_low_act` = 1, a low `strobe` enables the transfer and a high `strobe` blocks it.
- R8: With `stb_low_act` = 0, a high `strobe` enables the transfer and a low `strobe` blocks it.
- R9: With `multi_an` = 1, a transfer additionally needs `unit_sel` high. With `multi_an` = 0, `unit_sel` has no effect.
- R10: While a transfer is enabled, `route_n` equals `amux_sel_n`, which is the low-true code. Otherwise `route_n` is 4'hF.
- R11: After reset the registered code and the manual channel are 0, so `amux_sel_n` = 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = multiplex (event code), 0 = single channel (manual) |
| ev_code | input | 4 | Latched channel identity of the current event, true binary |
| ev_busy | input | 1 | High while an event is being routed |
| sel_pos | input | 5 | Manual selector position, valid range 1..16 |
| strobe | input | 1 | Transfer strobe from the analyzer |
| stb_low_act | input | 1 | 1 = strobe active low, 0 = strobe active high |
| multi_an | input | 1 | 1 = several analyzers present, so unit_sel is required |
| unit_sel | input | 1 | Select line addressing this unit |
| amux_sel_n | output | 4 | Inverted registered code to the analog multiplexer |
| route_n | output | 4 | Low-true routing code, all-high when not transferring |

## Verification
Every one of the 16 event codes is applied in multiplex mode. This shows that each code bit reaches the correct select line with the correct inversion. All 16 valid selector positions are then stepped through in single-channel mode, with a check one edge and two edges after each change. This separates the off-by-one position mapping from the two-stage latency. Out-of-range positions and changes made while busy are applied next; each must leave the previous channel in place. Finally, all 16 combinations of strobe level, strobe polarity, multi-analyzer setting and unit select are tried against a non-symmetric code. This tells a polarity inversion apart from a missing select qualification.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Strobe polarity configuration
    typedef enum logic {
        STB_ACT_HIGH = 1'b0,
        STB_ACT_LOW  = 1'b1
    } stb_pol_e;

    // Code source selection
    typedef enum logic {
        SRC_MANUAL = 1'b0,
        SRC_EVENT  = 1'b1
    } code_src_e;

endpackage

// File: rtl/rcs_manual_sel.sv
module rcs_manual_sel #(
    parameter int CODE_W = 4,
    parameter int POS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_busy,
    input  logic [POS_W-1:0]  sel_pos,
    output logic [CODE_W-1:0] man_chan
);
    localparam int NUM_CH = 1 << CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] chan;
    } man_state_t;

    man_state_t st_d, st_q;
    logic       pos_ok;

    always_comb begin
        st_d   = st_q;
        pos_ok = (sel_pos >= POS_W'(1)) && (sel_pos <= POS_W'(NUM_CH));
        if (!ev_busy && pos_ok) begin
            st_d.chan = CODE_W'(sel_pos - POS_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign man_chan = st_q.chan;
endmodule

// File: rtl/rcs_code_reg.sv
module rcs_code_reg
    import rcs_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_mode,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [CODE_W-1:0] man_chan,
    output logic [CODE_W-1:0] code_q_o,
    output logic [CODE_W-1:0] amux_sel_n
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } code_state_t;

    code_state_t st_d, st_q;
    code_src_e   src;

    always_comb begin
        src  = code_src_e'(mux_mode);
        st_d = st_q;
        if (src == SRC_EVENT) begin
            st_d.code = ev_code;
        end else begin
            st_d.code = man_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q_o = st_q.code;

    // Each select line is driven straight from a register bit, inverted.
    for (genvar i = 0; i < CODE_W; i++) begin : g_sel
        assign amux_sel_n[i] = ~st_q.code[i];
    end
endmodule

// File: rtl/rcs_xfer_gate.sv
module rcs_xfer_gate
    import rcs_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              strobe,
    input  logic              stb_low_act,
    input  logic              multi_an,
    input  logic              unit_sel,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] route_n
);
    stb_pol_e pol;
    logic     stb_active;
    logic     addr_ok;
    logic     gate_n;

    always_comb begin
        pol        = stb_pol_e'(stb_low_act);
        stb_active = (pol == STB_ACT_LOW) ? ~strobe : strobe;
        addr_ok    = ~multi_an | unit_sel;
        gate_n     = ~(stb_active & addr_ok);
    end

    // One OR gate per routing line: the common control must be low to pass.
    for (genvar i = 0; i < CODE_W; i++) begin : g_or
        assign route_n[i] = ~code[i] | gate_n;
    end
endmodule

// File: rtl/route_code_sel.sv
module route_code_sel #(
    parameter int CODE_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mux_mode,
    input  logic [CODE_W-1:0]                ev_code,
    input  logic                             ev_busy,
    input  logic [$clog2((1<<CODE_W)+1)-1:0] sel_pos,
    input  logic                             strobe,
    input  logic                             stb_low_act,
    input  logic                             multi_an,
    input  logic                             unit_sel,
    output logic [CODE_W-1:0]                amux_sel_n,
    output logic [CODE_W-1:0]                route_n
);
    localparam int NUM_CH = 1 << CODE_W;
    localparam int POS_W  = $clog2(NUM_CH + 1);

    logic [CODE_W-1:0] man_chan;
    logic [CODE_W-1:0] code_q;

    rcs_manual_sel #(.CODE_W(CODE_W), .POS_W(POS_W)) u_man (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_busy  (ev_busy),
        .sel_pos  (sel_pos),
        .man_chan (man_chan)
    );

    rcs_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_mode   (mux_mode),
        .ev_code    (ev_code),
        .man_chan   (man_chan),
        .code_q_o   (code_q),
        .amux_sel_n (amux_sel_n)
    );

    rcs_xfer_gate #(.CODE_W(CODE_W)) u_gate (
        .strobe      (strobe),
        .stb_low_act (stb_low_act),
        .multi_an    (multi_an),
        .unit_sel    (unit_sel),
        .code        (code_q),
        .route_n     (route_n)
    );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mux_mode,
    input logic [CODE_W-1:0] ev_code,
    input logic              ev_busy,
    input logic              strobe,
    input logic              stb_low_act,
    input logic              multi_an,
    input logic              unit_sel,
    input logic [CODE_W-1:0] amux_sel_n,
    input logic [CODE_W-1:0] route_n
);
    logic [1:0] arm_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (arm_q != 2'd3) begin
            arm_q <= arm_q + 2'd1;
        end
    end
    assign armed = (arm_q == 2'd3);

    AST_EVENT_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mux_mode)) |-> (amux_sel_n == ~$past(ev_code))); // R1

    AST_MANUAL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(mux_mode) && !$past(mux_mode, 2) && $past(ev_busy, 2))
        |-> $stable(amux_sel_n)); // R5

    AST_LOW_STROBE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_low_act && strobe) |-> (route_n == {CODE_W{1'b1}})); // R7

    AST_HIGH_STROBE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_low_act && !strobe) |-> (route_n == {CODE_W{1'b1}})); // R8

    AST_UNIT_NOT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_an && !unit_sel) |-> (route_n == {CODE_W{1'b1}})); // R9

    AST_ROUTE_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_low_act ? !strobe : strobe) && (!multi_an || unit_sel))
        |-> (route_n == amux_sel_n)); // R10
endmodule

bind route_code_sel rcs_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_mode    (mux_mode),
    .ev_code     (ev_code),
    .ev_busy     (ev_busy),
    .strobe      (strobe),
    .stb_low_act (stb_low_act),
    .multi_an    (multi_an),
    .unit_sel    (unit_sel),
    .amux_sel_n  (amux_sel_n),
    .route_n     (route_n)
);

// File: tb/route_code_sel_bench.sv
module route_code_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_mode = 1'b0;
    logic [3:0] ev_code = '0;
    logic       ev_busy = 1'b0;
    logic [4:0] sel_pos = '0;
    logic       strobe = 1'b1;
    logic       stb_low_act = 1'b1;
    logic       multi_an = 1'b0;
    logic       unit_sel = 1'b0;
    logic [3:0] amux_sel_n;
    logic [3:0] route_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    route_code_sel u_route_code_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux_mode    (mux_mode),
        .ev_code     (ev_code),
        .ev_busy     (ev_busy),
        .sel_pos     (sel_pos),
        .strobe      (strobe),
        .stb_low_act (stb_low_act),
        .multi_an    (multi_an),
        .unit_sel    (unit_sel),
        .amux_sel_n  (amux_sel_n),
        .route_n     (route_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] held;
        // R11: reset state, strobe inactive
        repeat (2) tick();
        check("R11 amux after reset", amux_sel_n, 4'hF);
        check("R11 route idle", route_n, 4'hF);
        rst_n = 1'b1;
        tick();
        check("R11 manual channel 0", amux_sel_n, 4'hF);

        // R1: every event code in multiplex mode, one clock latency
        mux_mode = 1'b1;
        for (int c = 0; c < 16; c++) begin
            ev_code = 4'(c);
            tick();
            check("R1 event code", amux_sel_n, ~4'(c));
        end

        // R2 + R3 + R6: manual positions 1..16
        mux_mode = 1'b0;
        sel_pos  = 5'd1;
        tick();
        tick();
        check("R2 manual after mode switch", amux_sel_n, ~4'd0);
        for (int p = 2; p <= 16; p++) begin
            sel_pos = 5'(p);
            tick();
            check("R6 one edge keeps old", amux_sel_n, ~4'(p - 2));
            tick();
            check("R3 position maps to channel", amux_sel_n, ~4'(p - 1));
        end

        // R4: out-of-range positions ignored
        sel_pos = 5'd6;
        repeat (2) tick();
        check("R3 position 6", amux_sel_n, ~4'd5);
        for (int b = 0; b < 32; b++) begin
            if (b == 0 || b > 16) begin
                sel_pos = 5'(b);
                repeat (3) tick();
                check("R4 invalid position ignored", amux_sel_n, ~4'd5);
            end
        end

        // R5: busy blocks sampling
        ev_busy = 1'b1;
        sel_pos = 5'd12;
        repeat (4) tick();
        check("R5 busy holds channel", amux_sel_n, ~4'd5);
        ev_busy = 1'b0;
        repeat (2) tick();
        check("R5 released samples", amux_sel_n, ~4'd11);

        // R2: multiplex then back to the held manual channel
        mux_mode = 1'b1;
        ev_code  = 4'd2;
        tick();
        check("R1 event overrides", amux_sel_n, ~4'd2);
        mux_mode = 1'b0;
        tick();
        check("R2 manual restored", amux_sel_n, ~4'd11);

        // R7..R10: gate sweep with non-symmetric code 4'b1011
        sel_pos = 5'd12;
        tick();
        tick();
        held = ~4'd11;
        for (int g = 0; g < 16; g++) begin
            logic en;
            stb_low_act = g[0];
            strobe      = g[1];
            multi_an    = g[2];
            unit_sel    = g[3];
            #1;
            en = (g[0] ? !g[1] : g[1]) && (!g[2] || g[3]);
            if (g[0])
                check("R7 active-low strobe gate", route_n, en ? held : 4'hF);
            else
                check("R8 active-high strobe gate", route_n, en ? held : 4'hF);
            if (g[2])
                check("R9 unit select qualifies", route_n, en ? held : 4'hF);
            check("R10 route low-true or idle", route_n, en ? amux_sel_n : 4'hF);
        end

        // R10: enabled route follows code changes
        stb_low_act = 1'b0;
        strobe      = 1'b1;
        multi_an    = 1'b0;
        mux_mode    = 1'b1;
        for (int c = 0; c < 16; c++) begin
            ev_code = 4'(15 - c);
            tick();
            check("R10 route carries code", route_n, ~4'(15 - c));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule